// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the transmit and receive error counts of a CAN controller and works out the node's fault-confinement state from them. The bus-side logic reports what happened on the bus as single-cycle pulses: a transmit error, a receive error that counts one, a receive error that counts eight, a good transmission and a good reception. The block applies the counting rules of the protocol to these pulses and reports the state as error active, error passive or bus off. It raises a one-cycle alert to the host on every change of state.

Once the node is bus off, it ignores all counting events. Recovery then needs a fixed number of idle runs, each run being eleven consecutive recessive bits that the bus logic reports as a pulse on `idle_run_i`. After the last of these runs, both counts clear and the node is error active again. In normal operation the counts are read-only. A test-mode write port can load either counter directly.

Top module: `can_fault_counters`

## Requirements
- R1: After a synchronous reset both counts are 0, `state_o` is 0 (error active) and `alert_o` is 0.
- R2: `tx_err_i` adds 8 to the transmit count. `tx_ok_i` subtracts 1 from it, and a count of 0 stays at 0.
- R3: On the receive count, `rx_err_i` adds 1 and `rx_err8_i` adds 8. When both pulse together they add 9. The receive count saturates at 255, and a receive increment never puts the node into bus off.
- R4: `rx_ok_i` subtracts 1 from a receive count between 1 and 127 and leaves a count of 0 alone. If the receive count is 128 or more, `rx_ok_i` loads it with 120.
- R5: When an error pulse and a success pulse reach the same counter in the same cycle, only the error is applied.
- R6: `state_o` encodes error active as 0, error passive as 1 and bus off as 2. Outside bus off, the state is 1 when either count is 128 or more and 0 when both are 127 or less.
- R7: Suppose `tx_err_i` pulses while the transmit count is 248 or more. The transmit count then becomes 255 and the state becomes bus off (2). Below 248, an increment that reaches at most 255 does not cause bus off.
- R8: While the node is bus off, all five counting pulses are ignored.
- R9: While bus off, the 128th `idle_run_i` pulse clears both counts and returns the state to error active. Outside bus off, `idle_run_i` has no effect.
- R10: `alert_o` is high for exactly the one cycle in which `state_o` takes a new value, and is low at all other times.
- R11: With `test_mode_i` high, `wr_tx_i` loads `wr_data_i` into the transmit count and `wr_rx_i` loads it into the receive count. A load takes priority over counting pulses in the same cycle. With `test_mode_i` low, both writes are ignored.
- R12: All four outputs take their new values at the rising clock edge that samples the input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_i | input | 1 | Transmit error pulse (+8) |
| rx_err_i | input | 1 | Receive error pulse (+1) |
| rx_err8_i | input | 1 | Receive error pulse (+8) |
| tx_ok_i | input | 1 | Good transmission pulse |
| rx_ok_i | input | 1 | Good reception pulse |
| idle_run_i | input | 1 | One run of 11 recessive bits seen |
| test_mode_i | input | 1 | Enables the counter write port |
| wr_tx_i | input | 1 | Load transmit count from `wr_data_i` |
| wr_rx_i | input | 1 | Load receive count from `wr_data_i` |
| wr_data_i | input | 8 | Value to load |
| tx_count_o | output | 8 | Transmit error count |
| rx_count_o | output | 8 | Receive error count |
| state_o | output | 2 | 0 active, 1 passive, 2 bus off |
| alert_o | output | 1 | One-cycle pulse on a change of state |

## Verification
Every result of this block is due one clock edge after its stimulus. The counts, the state and the alert are all registered at the same edge, the one that samples the pulse or the write. The driver holds each stimulus across one rising edge and pushes the expected counts, state and alert into a queue just after that edge. The monitor pops and compares them at the following falling edge, so each comparison lands exactly one edge after its stimulus, and a late alert or state shows up as a mismatch.

// File: rtl/can_fc_pkg.sv
// Shared types for the fault confinement counters.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/can_fc_tx_cnt.sv
// Transmit error counter.
// Adds STEP on an error and takes one away on a success, never dropping below zero.
// An error that would pass the top of the range saturates the count and flags an overflow.
// Priority order: recovery clear, then test write, then freeze (bus off), then the
// error, then the success.
// Assumes the event pulses last one cycle.
module can_fc_tx_cnt #(
    parameter int CNT_W = 8,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ok_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] next_o,
    output logic             overflow_o
);
    localparam logic [CNT_W-1:0] MAX_V   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIMIT_V = MAX_V - CNT_W'(STEP);

    logic [CNT_W-1:0] count_q;

    // Work out the next count from the events and their priority.
    always_comb begin
        next_o = count_q;
        if (clear_i) begin
            next_o = '0;
        end else if (wr_i) begin
            next_o = wr_data_i;
        end else if (freeze_i) begin
            next_o = count_q;
        end else if (err_i) begin
            next_o = (count_q > LIMIT_V) ? MAX_V : count_q + CNT_W'(STEP);
        end else if (ok_i && count_q != '0) begin
            next_o = count_q - 1'b1;
        end
    end

    // Flag an error increment that would pass the top of the range.
    always_comb overflow_o = !clear_i && !wr_i && !freeze_i && err_i && (count_q > LIMIT_V);

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= next_o;
    end

    assign count_o = count_q;

    assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !wr_i && !freeze_i && !clear_i && count_q <= LIMIT_V)
        |=> count_q == $past(count_q) + CNT_W'(STEP));

    assert_tx_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_i && !err_i && !wr_i && !freeze_i && !clear_i && count_q == '0)
        |=> count_q == '0);

    assert_tx_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> count_q == MAX_V);

    assert_tx_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !wr_i && !clear_i) |=> $stable(count_q));
endmodule

// File: rtl/can_fc_rx_cnt.sv
// Receive error counter.
// Adds one or STEP (or both) on errors and saturates at the top of the range.
// A success takes one away, but above the passive threshold it loads PRESET instead.
// An error outranks a success in the same cycle.
// Assumes PRESET lies below PASSIVE_TH.
module can_fc_rx_cnt #(
    parameter int CNT_W      = 8,
    parameter int STEP       = 8,
    parameter int PASSIVE_TH = 128,
    parameter int PRESET     = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err1_i,
    input  logic             err8_i,
    input  logic             ok_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] next_o
);
    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TH_V  = CNT_W'(PASSIVE_TH);
    localparam logic [CNT_W-1:0] PRE_V = CNT_W'(PRESET);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   sum;

    // Widened sum of the error increments, used for saturation.
    always_comb begin
        sum = {1'b0, count_q};
        if (err1_i) sum = sum + (CNT_W+1)'(1);
        if (err8_i) sum = sum + (CNT_W+1)'(STEP);
    end

    // Work out the next count from the events and their priority.
    always_comb begin
        next_o = count_q;
        if (clear_i) begin
            next_o = '0;
        end else if (wr_i) begin
            next_o = wr_data_i;
        end else if (freeze_i) begin
            next_o = count_q;
        end else if (err1_i || err8_i) begin
            next_o = sum[CNT_W] ? MAX_V : sum[CNT_W-1:0];
        end else if (ok_i) begin
            if (count_q >= TH_V)        next_o = PRE_V;
            else if (count_q != '0)     next_o = count_q - 1'b1;
        end
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= next_o;
    end

    assign count_o = count_q;

    assert_rx_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_i && !err1_i && !err8_i && !wr_i && !freeze_i && !clear_i && count_q >= TH_V)
        |=> count_q == PRE_V);

    assert_rx_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err8_i && !wr_i && !freeze_i && !clear_i && count_q > MAX_V - CNT_W'(STEP))
        |=> count_q == MAX_V);

    assert_rx_err_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err1_i && !err8_i && ok_i && !wr_i && !freeze_i && !clear_i && count_q != MAX_V)
        |=> count_q == $past(count_q) + 1'b1);

    assert_rx_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !wr_i && !clear_i) |=> $stable(count_q));
endmodule

// File: rtl/can_fc_state.sv
// Fault confinement state tracker.
// Keeps the bus-off flag and counts recovery runs while the node is bus off.
// Computes the state from the next counter values, so the state and the alert
// change at the same edge as the counts.
// Assumes idle_run_i pulses once per run of 11 recessive bits.
module can_fc_state
    import can_fc_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PASSIVE_TH = 128,
    parameter int RECOV_RUNS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             overflow_i,
    input  logic             idle_run_i,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [CNT_W-1:0] tx_next_i,
    input  logic [CNT_W-1:0] rx_next_i,
    output logic             busoff_o,
    output logic             clear_o,
    output fc_state_e        state_o,
    output logic             alert_o
);
    localparam int REC_W = (RECOV_RUNS > 1) ? $clog2(RECOV_RUNS) : 1;
    localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOV_RUNS - 1);
    localparam logic [CNT_W-1:0] TH_V     = CNT_W'(PASSIVE_TH);

    logic             busoff_q, busoff_d;
    logic [REC_W-1:0] rec_q;
    fc_state_e        state_q, state_d;
    logic             alert_q;

    // Recovery finishes on the last idle run while bus off.
    always_comb clear_o = busoff_q && idle_run_i && (rec_q == REC_LAST);

    // The bus-off flag is set by a transmit overflow and cleared by recovery.
    always_comb begin
        busoff_d = busoff_q;
        if (clear_o)         busoff_d = 1'b0;
        else if (overflow_i) busoff_d = 1'b1;
    end

    // Decode the state from the flag and the next counts.
    always_comb begin
        if (busoff_d)                                    state_d = FC_BUSOFF;
        else if (tx_next_i >= TH_V || rx_next_i >= TH_V) state_d = FC_PASSIVE;
        else                                             state_d = FC_ACTIVE;
    end

    // Register the flag, the state and the change alert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busoff_q <= 1'b0;
            state_q  <= FC_ACTIVE;
            alert_q  <= 1'b0;
        end else begin
            busoff_q <= busoff_d;
            state_q  <= state_d;
            alert_q  <= (state_d != state_q);
        end
    end

    // Count idle runs while bus off and restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !busoff_q || clear_o) rec_q <= '0;
        else if (idle_run_i)                rec_q <= rec_q + 1'b1;
    end

    assign busoff_o = busoff_q;
    assign state_o  = state_q;
    assign alert_o  = alert_q;

    assert_alert_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> alert_q == (state_q != $past(state_q)));

    assert_state_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_BUSOFF) == busoff_q);

    assert_passive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busoff_q |-> ((state_q == FC_PASSIVE) == (tx_cnt_i >= TH_V || rx_cnt_i >= TH_V)));

    assert_recov_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (tx_cnt_i == '0 && rx_cnt_i == '0 && state_q == FC_ACTIVE));

    assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_i |=> state_q == FC_BUSOFF);
endmodule

// File: rtl/can_fault_counters.sv
// Top level of the fault confinement counters.
// Gates the write port with test mode and wires the two counters to the state tracker.
// The bus-off flag freezes both counters, and the end of recovery clears them.
// Assumes all event inputs are synchronous single-cycle pulses.
module can_fault_counters #(
    parameter int CNT_W      = 8,
    parameter int ERR_STEP   = 8,
    parameter int PASSIVE_TH = 128,
    parameter int RX_PRESET  = 120,
    parameter int RECOV_RUNS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             rx_err8_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             idle_run_i,
    input  logic             test_mode_i,
    input  logic             wr_tx_i,
    input  logic             wr_rx_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] tx_count_o,
    output logic [CNT_W-1:0] rx_count_o,
    output logic [1:0]       state_o,
    output logic             alert_o
);
    import can_fc_pkg::*;

    logic             wr_tx_en, wr_rx_en;
    logic             busoff, clear, overflow;
    logic [CNT_W-1:0] tx_next, rx_next;
    fc_state_e        state;

    // Writes count only in test mode.
    always_comb begin
        wr_tx_en = test_mode_i && wr_tx_i;
        wr_rx_en = test_mode_i && wr_rx_i;
    end

    can_fc_tx_cnt #(.CNT_W(CNT_W), .STEP(ERR_STEP)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_i     (tx_err_i),
        .ok_i      (tx_ok_i),
        .freeze_i  (busoff),
        .clear_i   (clear),
        .wr_i      (wr_tx_en),
        .wr_data_i (wr_data_i),
        .count_o   (tx_count_o),
        .next_o    (tx_next),
        .overflow_o(overflow)
    );

    can_fc_rx_cnt #(.CNT_W(CNT_W), .STEP(ERR_STEP), .PASSIVE_TH(PASSIVE_TH),
                    .PRESET(RX_PRESET)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .err1_i   (rx_err_i),
        .err8_i   (rx_err8_i),
        .ok_i     (rx_ok_i),
        .freeze_i (busoff),
        .clear_i  (clear),
        .wr_i     (wr_rx_en),
        .wr_data_i(wr_data_i),
        .count_o  (rx_count_o),
        .next_o   (rx_next)
    );

    can_fc_state #(.CNT_W(CNT_W), .PASSIVE_TH(PASSIVE_TH), .RECOV_RUNS(RECOV_RUNS)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .overflow_i(overflow),
        .idle_run_i(idle_run_i),
        .tx_cnt_i  (tx_count_o),
        .rx_cnt_i  (rx_count_o),
        .tx_next_i (tx_next),
        .rx_next_i (rx_next),
        .busoff_o  (busoff),
        .clear_o   (clear),
        .state_o   (state),
        .alert_o   (alert_o)
    );

    assign state_o = state;

    assert_write_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode_i && !tx_err_i && !tx_ok_i && !clear) |=> $stable(tx_count_o));
endmodule

// File: tb/tb_can_fault_counters.sv
`timescale 1ns/1ps
module tb_can_fault_counters;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err, rx_err, rx_err8, tx_ok, rx_ok, run;
    logic       tm, wtx, wrx;
    logic [7:0] wd;
    logic [7:0] tx_cnt, rx_cnt;
    logic [1:0] st;
    logic       alert;

    int checks = 0;
    int errors = 0;

    // Event masks {tx_err, rx_err, rx_err8, tx_ok, rx_ok, run}
    localparam logic [5:0] TXE = 6'b100000, RXE = 6'b010000, RX8 = 6'b001000,
                           TXK = 6'b000100, RXK = 6'b000010, RUN = 6'b000001, NONE = 6'b0;
    // Write masks {test_mode, wr_tx, wr_rx}
    localparam logic [2:0] W0 = 3'b000;

    // Requirement model state
    int m_tx = 0, m_rx = 0, m_st = 0, m_rec = 0;
    bit m_bo = 0;

    logic [18:0] q_val[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    can_fault_counters dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_i(tx_err), .rx_err_i(rx_err), .rx_err8_i(rx_err8),
        .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .idle_run_i(run),
        .test_mode_i(tm), .wr_tx_i(wtx), .wr_rx_i(wrx), .wr_data_i(wd),
        .tx_count_o(tx_cnt), .rx_count_o(rx_cnt), .state_o(st), .alert_o(alert)
    );

    // Driver: apply one cycle of stimulus, update the model, push the expectation.
    task automatic step(input logic [5:0] ev, input logic [2:0] w,
                        input logic [7:0] d, input string tag);
        int  prev;
        bit  cleared;
        @(negedge clk);
        {tx_err, rx_err, rx_err8, tx_ok, rx_ok, run} = ev;
        {tm, wtx, wrx} = w;
        wd = d;
        @(posedge clk);
        #1;
        prev = m_st;
        cleared = 0;
        if (m_bo) begin
            if (ev[0]) begin
                m_rec++;
                if (m_rec == 128) begin
                    m_tx = 0; m_rx = 0; m_bo = 0; m_rec = 0; cleared = 1;
                end
            end
            if (!cleared && w[2] && w[1]) m_tx = d;
            if (!cleared && w[2] && w[0]) m_rx = d;
        end else begin
            if (w[2] && w[1]) m_tx = d;
            else if (ev[5]) begin
                if (m_tx >= 248) begin m_tx = 255; m_bo = 1; m_rec = 0; end
                else m_tx += 8;
            end else if (ev[2] && m_tx > 0) m_tx--;
            if (w[2] && w[0]) m_rx = d;
            else if (ev[4] || ev[3]) begin
                m_rx += (ev[4] ? 1 : 0) + (ev[3] ? 8 : 0);
                if (m_rx > 255) m_rx = 255;
            end else if (ev[1]) begin
                if (m_rx >= 128) m_rx = 120;
                else if (m_rx > 0) m_rx--;
            end
        end
        m_st = m_bo ? 2 : ((m_tx >= 128 || m_rx >= 128) ? 1 : 0);
        q_val.push_back({8'(m_tx), 8'(m_rx), 2'(m_st), (m_st != prev)});
        q_tag.push_back(tag);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each expectation one falling edge after its sampling edge.
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            logic [18:0] e;
            string t;
            e = q_val.pop_front();
            t = q_tag.pop_front();
            chk(t, "tx_count", int'(tx_cnt), int'(e[18:11]));
            chk(t, "rx_count", int'(rx_cnt), int'(e[10:3]));
            chk(t, "state",    int'(st),     int'(e[2:1]));
            chk(t, "alert",    int'(alert),  int'(e[0]));
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        {tx_err, rx_err, rx_err8, tx_ok, rx_ok, run, tm, wtx, wrx} = '0;
        wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(NONE, W0, 0, "R1");
        // R2 transmit counting and floor at zero
        repeat (3) step(TXE, W0, 0, "R2");
        repeat (30) step(TXK, W0, 0, "R2");
        // R3 receive increments of 1, 8 and 9
        step(RXE, W0, 0, "R3");
        step(RX8, W0, 0, "R3");
        step(RXE | RX8, W0, 0, "R3");
        // R4 receive decrement and floor
        repeat (20) step(RXK, W0, 0, "R4");
        // R5 error outranks success
        step(TXE | TXK, W0, 0, "R5");
        step(RXE | RXK, W0, 0, "R5");
        repeat (8) step(TXK, W0, 0, "R5");
        step(RXK, W0, 0, "R5");
        // R6 R10 passive entry on the receive side, R4 preset back to active
        repeat (16) step(RX8, W0, 0, "R6");
        step(RXK, W0, 0, "R4");
        // R3 saturation without bus off
        repeat (20) step(RX8, W0, 0, "R3");
        step(RXK, W0, 0, "R4");
        // R6 R10 passive entry on the transmit side and exit
        repeat (16) step(TXE, W0, 0, "R6");
        step(TXK, W0, 0, "R10");
        // R11 writes ignored outside test mode, applied inside, priority over events
        step(NONE, 3'b011, 8'd200, "R11");
        step(NONE, 3'b101, 8'd5, "R11");
        step(TXE, 3'b110, 8'd247, "R11");
        // R7 247 + 8 reaches 255 without bus off, next error enters bus off
        step(TXE, W0, 0, "R7");
        step(TXE, W0, 0, "R7");
        // R8 events ignored while bus off
        repeat (3) step(TXE | RXE | RX8 | TXK | RXK, W0, 0, "R8");
        // R9 recovery after 128 idle runs
        repeat (127) step(RUN, W0, 0, "R9");
        step(RUN, W0, 0, "R9");
        repeat (5) step(RUN, W0, 0, "R9");
        // R7 bus off from exactly 248, then recovery again
        step(NONE, 3'b110, 8'd248, "R7");
        step(TXE, W0, 0, "R7");
        repeat (128) step(RUN, W0, 0, "R9");
        // R12 quiet cycle confirms settled outputs
        step(NONE, W0, 0, "R12");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule